// File: doc/BRIEF.md
# ATA Programmed-I/O Register Access Sequencer

This block connects a simple host register bus to a parallel ATA device port. It runs exactly one programmed-I/O register access at a time, either a read or a write. The host gives a byte offset. The block translates that offset into the two chip-select lines and the three device-address lines. It then waits through a programmable address-setup interval and pulses the read or write strobe low for a programmable number of clocks. After the strobe, it holds the address for one more clock. Reads return the 16-bit device bus value to the host. Writes drive the host data onto the device bus.

A small profile register holds an enable bit and the two timing counts. The counts reset to values suited to the slowest transfer mode: setup 7, strobe 13. Software first talks to the device at those settings. After it has switched the device to the fastest mode, it can shorten the counts, for example to setup 1, strobe 3. An offset outside the register map finishes at once with an error flag.

The sequencer has five states:
- **IDLE**: waiting for a request.
- **SETUP**: address driven, strobe high.
- **STROBE**: strobe low.
- **HOLD**: address held, strobe high.
- **DONE**: completion pulse.

Its transitions are:
- IDLE→SETUP on an accepted mapped request.
- IDLE→DONE on an accepted unmapped request.
- SETUP→STROBE when the setup count expires.
- STROBE→HOLD when the strobe count expires.
- HOLD→DONE always.
- DONE→IDLE always.

Top module: `ata_pio_seq`

## Requirements
- R1: Offsets 0x40, 0x44, 0x48, 0x4C, 0x50, 0x54, 0x58, 0x5C drive dev_cs = 2'b10 (bit 1 is CS1 = 1, bit 0 is CS0 = 0) and dev_da = 0,1,...,7 respectively, for the whole access.
- R2: Offset 0x38 drives dev_cs = 2'b01 and dev_da = 3'b110 for the whole access.
- R3: An accepted request to any other offset enters DONE on the next clock with bus_err = 1. No strobe falls and dev_cs stays 2'b11.
- R4: After the address is driven, both strobes stay high for the programmed setup count of clocks. A count of 0 acts as 1.
- R5: The strobe is then low for the programmed strobe count of clocks (0 acts as 1). Reads pull only dior_n low and writes pull only diow_n low.
- R6: After the strobe rises, dev_cs and dev_da hold their values for exactly one clock. They then return to idle: dev_cs = 2'b11, dev_da = 0.
- R7: After reset, the enable bit is 0, the setup count is 7 and the strobe count is 13. Outputs are idle: strobes high, dd_oe = 0, busy = 0, done = 0, bus_err = 0, rdata = 0.
- R8: While the enable bit is 0, req_ready is 0 and requests cause no activity.
- R9: For a read, rdata takes dd_in as sampled on the clock edge on which dior_n rises. rdata then keeps that value through later writes and errors. bus_err clears on the next mapped access.
- R10: For a write, dd_oe = 1 and dd_out = the write data in every SETUP, STROBE and HOLD clock. dd_oe is 0 during reads.
- R11: busy is 1 from the clock after acceptance through the DONE clock. done is a single-clock pulse. req_ready is 0 whenever busy is 1.
- R12: A timing write between accesses takes effect on the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_we | input | 1 | Write strobe for the enable bit |
| cfg_en_d | input | 1 | New enable bit value |
| cfg_time_we | input | 1 | Write strobe for both timing counts |
| cfg_setup_d | input | 8 | New setup (strobe-high) count in clocks |
| cfg_pulse_d | input | 8 | New strobe-low count in clocks |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Host byte offset |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| bus_err | output | 1 | Last access hit an unmapped offset |
| rdata | output | 16 | Data from the last read |
| dev_cs | output | 2 | Chip selects {CS1, CS0}, idle 2'b11 |
| dev_da | output | 3 | Device register address |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_in | input | 16 | Device data bus, inbound |
| dd_out | output | 16 | Device data bus, outbound |
| dd_oe | output | 1 | Outbound data enable |

## Verification
The main access path is exercised three ways:
- Every command-block offset is used in reads and writes, which separates one address decode from another.
- The control-block offset is used in both directions, which shows the opposite chip-select pairing.
- Several unmapped offsets are used, including one only a byte off a mapped one. These show a strict match rather than a masked one.

Each access is timed under three profiles: the reset counts, short counts, and zero counts. Cycle-exact phase lengths separate the setup, strobe and hold counters from each other. The device model presents valid data only while dior_n is low, so capture on the wrong edge gives a distinct value. An error access placed after a read shows whether rdata is kept.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] cs;
        logic [2:0] da;
    } reg_sel_t;

    localparam logic [1:0] CS_IDLE = 2'b11;
    localparam logic [1:0] CS_CMD  = 2'b10;
    localparam logic [1:0] CS_CTL  = 2'b01;

endpackage

// File: rtl/ata_pio_decode.sv
module ata_pio_decode
    import ata_pio_pkg::*;
#(
    parameter int               OFS_W       = 8,
    parameter logic [OFS_W-1:0] CMD_BASE    = 8'h40,
    parameter logic [OFS_W-1:0] CTL_OFS     = 8'h38,
    parameter logic [2:0]       CTL_DA      = 3'b110,
    parameter int               STRIDE_LOG2 = 2
) (
    input  logic [OFS_W-1:0] offset,
    output reg_sel_t         sel
);
    localparam int NREG = 8;

    logic [NREG-1:0] cmd_hit;

    for (genvar i = 0; i < NREG; i++) begin : g_cmd
        assign cmd_hit[i] = (offset == CMD_BASE + (OFS_W'(i) << STRIDE_LOG2));
    end

    always_comb begin
        sel.hit = 1'b0;
        sel.cs  = CS_IDLE;
        sel.da  = 3'd0;
        if (|cmd_hit) begin
            sel.hit = 1'b1;
            sel.cs  = CS_CMD;
            for (int k = 0; k < NREG; k++) begin
                if (cmd_hit[k]) sel.da = 3'(k);
            end
        end else if (offset == CTL_OFS) begin
            sel.hit = 1'b1;
            sel.cs  = CS_CTL;
            sel.da  = CTL_DA;
        end
    end
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? CW'(1) : load_val;
        end else if (cnt > CW'(1)) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expire = (cnt <= CW'(1));
endmodule

// File: rtl/ata_pio_cfg.sv
module ata_pio_cfg #(
    parameter int            CW        = 8,
    parameter logic [CW-1:0] SETUP_RST = 8'd7,
    parameter logic [CW-1:0] PULSE_RST = 8'd13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_we,
    input  logic          en_d,
    input  logic          time_we,
    input  logic [CW-1:0] setup_d,
    input  logic [CW-1:0] pulse_d,
    output logic          enable,
    output logic [CW-1:0] setup_q,
    output logic [CW-1:0] pulse_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable  <= 1'b0;
            setup_q <= SETUP_RST;
            pulse_q <= PULSE_RST;
        end else begin
            if (en_we)   enable  <= en_d;
            if (time_we) setup_q <= setup_d;
            if (time_we) pulse_q <= pulse_d;
        end
    end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int DW    = 16,
    parameter int CW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en_we,
    input  logic             cfg_en_d,
    input  logic             cfg_time_we,
    input  logic [CW-1:0]    cfg_setup_d,
    input  logic [CW-1:0]    cfg_pulse_d,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFS_W-1:0] req_offset,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic             busy,
    output logic             done,
    output logic             bus_err,
    output logic [DW-1:0]    rdata,
    output logic [1:0]       dev_cs,
    output logic [2:0]       dev_da,
    output logic             dior_n,
    output logic             diow_n,
    input  logic [DW-1:0]    dd_in,
    output logic [DW-1:0]    dd_out,
    output logic             dd_oe
);
    seq_state_t    state, nxt;
    reg_sel_t      sel_dec, sel_q;
    logic          prof_en;
    logic [CW-1:0] setup_q, pulse_q;
    logic          accept, t_load, t_expire;
    logic [CW-1:0] t_val;
    logic          wr_q;
    logic [DW-1:0] wdata_q;

    ata_pio_cfg #(.CW(CW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (cfg_en_we),
        .en_d    (cfg_en_d),
        .time_we (cfg_time_we),
        .setup_d (cfg_setup_d),
        .pulse_d (cfg_pulse_d),
        .enable  (prof_en),
        .setup_q (setup_q),
        .pulse_q (pulse_q)
    );

    ata_pio_decode #(.OFS_W(OFS_W)) u_dec (
        .offset (req_offset),
        .sel    (sel_dec)
    );

    assign accept = req_valid && req_ready;
    assign t_load = (state == ST_IDLE && accept) || (state == ST_SETUP && t_expire);
    assign t_val  = (state == ST_IDLE) ? setup_q : pulse_q;

    ata_pio_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expire   (t_expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) nxt = sel_dec.hit ? ST_SETUP : ST_DONE;
            ST_SETUP:  if (t_expire) nxt = ST_STROBE;
            ST_STROBE: if (t_expire) nxt = ST_HOLD;
            ST_HOLD:   nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // access context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '{hit: 1'b0, cs: CS_IDLE, da: 3'd0};
            wr_q    <= 1'b0;
            wdata_q <= '0;
            bus_err <= 1'b0;
            rdata   <= '0;
        end else begin
            if (state == ST_IDLE && accept) begin
                sel_q   <= sel_dec;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
                bus_err <= !sel_dec.hit;
            end
            if (state == ST_STROBE && t_expire && !wr_q) begin
                rdata <= dd_in;
            end
        end
    end

    // outputs
    always_comb begin
        dev_cs    = CS_IDLE;
        dev_da    = 3'd0;
        dior_n    = 1'b1;
        diow_n    = 1'b1;
        dd_oe     = 1'b0;
        dd_out    = wdata_q;
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        req_ready = (state == ST_IDLE) && prof_en;
        unique case (state)
            ST_SETUP, ST_HOLD: begin
                dev_cs = sel_q.cs;
                dev_da = sel_q.da;
                dd_oe  = wr_q;
            end
            ST_STROBE: begin
                dev_cs = sel_q.cs;
                dev_da = sel_q.da;
                dd_oe  = wr_q;
                dior_n = wr_q;
                diow_n = !wr_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prof_en,
    input logic       req_ready,
    input logic       busy,
    input logic       done,
    input logic       bus_err,
    input logic [1:0] dev_cs,
    input logic [2:0] dev_da,
    input logic       dior_n,
    input logic       diow_n,
    input logic       dd_oe
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n)); // R5
    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n || !diow_n) |-> (dev_cs != 2'b11) && busy); // R5
    AST_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dior_n) || $rose(diow_n)) |-> (dev_cs != 2'b11) && $stable(dev_cs) && $stable(dev_da)); // R6
    AST_HOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dior_n) || $rose(diow_n)) |=> (dev_cs == 2'b11) && done); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy); // R11
    AST_DISABLED_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !prof_en |-> !req_ready); // R8
    AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !diow_n |-> dd_oe); // R10
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !dior_n |-> !dd_oe); // R10
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bus_err) |-> (dev_cs == 2'b11) && dior_n && diow_n); // R3
endmodule

bind ata_pio_seq ata_pio_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prof_en   (prof_en),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .bus_err   (bus_err),
    .dev_cs    (dev_cs),
    .dev_da    (dev_da),
    .dior_n    (dior_n),
    .diow_n    (diow_n),
    .dd_oe     (dd_oe)
);

// File: tb/ata_pio_seq_bench.sv
`timescale 1ns/1ps
module ata_pio_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en_we = 1'b0, cfg_en_d = 1'b0, cfg_time_we = 1'b0;
    logic [7:0]  cfg_setup_d = '0, cfg_pulse_d = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_offset = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, busy, done, bus_err;
    logic [15:0] rdata, dd_in, dd_out;
    logic [1:0]  dev_cs;
    logic [2:0]  dev_da;
    logic        dior_n, diow_n, dd_oe;
    logic [15:0] dev_val = '0;

    int checks = 0;
    int errors = 0;
    int cur_hi = 7;
    int cur_lo = 13;
    logic [15:0] last_rd = '0;

    always #2 clk = ~clk;

    // device answers only while the read strobe is low
    assign dd_in = !dior_n ? dev_val : 16'hDEAD;

    ata_pio_seq u_ata_pio_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_en_we(cfg_en_we), .cfg_en_d(cfg_en_d), .cfg_time_we(cfg_time_we),
        .cfg_setup_d(cfg_setup_d), .cfg_pulse_d(cfg_pulse_d),
        .req_valid(req_valid), .req_write(req_write), .req_offset(req_offset),
        .req_wdata(req_wdata), .req_ready(req_ready), .busy(busy), .done(done),
        .bus_err(bus_err), .rdata(rdata), .dev_cs(dev_cs), .dev_da(dev_da),
        .dior_n(dior_n), .diow_n(diow_n), .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe)
    );

    // {write, offset, wdata, device value, err, cs, da}
    localparam int NV = 13;
    localparam logic [46:0] VECS [NV] = '{
        {1'b0, 8'h40, 16'h0000, 16'h1234, 1'b0, 2'b10, 3'd0},
        {1'b1, 8'h44, 16'hBEEF, 16'h0000, 1'b0, 2'b10, 3'd1},
        {1'b0, 8'h48, 16'h0000, 16'h00A5, 1'b0, 2'b10, 3'd2},
        {1'b1, 8'h4C, 16'h0F0F, 16'h0000, 1'b0, 2'b10, 3'd3},
        {1'b0, 8'h50, 16'h0000, 16'h5A5A, 1'b0, 2'b10, 3'd4},
        {1'b0, 8'h3C, 16'h0000, 16'h7777, 1'b1, 2'b11, 3'd0},
        {1'b1, 8'h54, 16'hC3C3, 16'h0000, 1'b0, 2'b10, 3'd5},
        {1'b0, 8'h58, 16'h0000, 16'h8001, 1'b0, 2'b10, 3'd6},
        {1'b1, 8'h5C, 16'h00EC, 16'h0000, 1'b0, 2'b10, 3'd7},
        {1'b0, 8'h38, 16'h0000, 16'h0050, 1'b0, 2'b01, 3'd6},
        {1'b1, 8'h41, 16'h1111, 16'h0000, 1'b1, 2'b11, 3'd0},
        {1'b1, 8'h38, 16'h0004, 16'h0000, 1'b0, 2'b01, 3'd6},
        {1'b0, 8'h60, 16'h0000, 16'h2222, 1'b1, 2'b11, 3'd0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_time(input int hi, input int lo);
        @(negedge clk);
        cfg_time_we = 1'b1; cfg_setup_d = 8'(hi); cfg_pulse_d = 8'(lo);
        @(negedge clk);
        cfg_time_we = 1'b0;
        cur_hi = (hi == 0) ? 1 : hi;
        cur_lo = (lo == 0) ? 1 : lo;
    endtask

    task automatic set_en(input bit en);
        @(negedge clk);
        cfg_en_we = 1'b1; cfg_en_d = en;
        @(negedge clk);
        cfg_en_we = 1'b0;
    endtask

    task automatic access(input bit wr, input logic [7:0] off, input logic [15:0] wd,
                          input logic [15:0] dv, input bit eerr,
                          input logic [1:0] ecs, input logic [2:0] eda);
        int n_setup = 0, n_pulse = 0, n_hold = 0, cyc = 0;
        int bad_sel = 0, bad_kind = 0, bad_oe = 0, rdy_busy = 0, not_busy = 0;
        bit seen = 0;
        string rsel = (off == 8'h38) ? "R2" : "R1";
        @(negedge clk);
        dev_val = dv; req_valid = 1'b1; req_write = wr; req_offset = off; req_wdata = wd;
        check("R11", "ready when idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 2000) begin
            cyc++;
            if (!busy) not_busy++;
            if (req_ready) rdy_busy++;
            if (dior_n && diow_n) begin
                if (seen) n_hold++; else n_setup++;
            end else begin
                seen = 1;
                n_pulse++;
                if (wr ? (diow_n || !dior_n) : (dior_n || !diow_n)) bad_kind++;
            end
            if (dev_cs != ecs || dev_da != eda) bad_sel++;
            if (dd_oe != wr || (wr && dd_out != wd)) bad_oe++;
            @(negedge clk);
        end
        check("R11", "done reached", 32'(done), 32'd1);
        check("R11", "busy in done clock", 32'(busy), 32'd1);
        check("R11", "busy and ready in access", 32'(not_busy + rdy_busy), 32'd0);
        check("R3", "bus_err", 32'(bus_err), 32'(eerr));
        check("R4", "setup clocks", 32'(n_setup), eerr ? 32'd0 : 32'(cur_hi));
        check("R5", "strobe clocks", 32'(n_pulse), eerr ? 32'd0 : 32'(cur_lo));
        check("R6", "hold clocks", 32'(n_hold), eerr ? 32'd0 : 32'd1);
        check("R5", "strobe kind", 32'(bad_kind), 32'd0);
        check(rsel, "select lines", 32'(bad_sel), 32'd0);
        check("R10", "data drive", 32'(bad_oe), 32'd0);
        check("R6", "cs idle at done", 32'(dev_cs), 32'h3);
        if (!wr && !eerr) last_rd = dv;
        check("R9", "rdata", 32'(rdata), 32'(last_rd));
        @(negedge clk);
        check("R11", "done one clock", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7", "busy after reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", "idle cs", 32'(dev_cs), 32'h3);
        check("R7", "idle da", 32'(dev_da), 32'd0);
        check("R7", "idle strobes", 32'({dior_n, diow_n}), 32'h3);
        check("R7", "idle oe/done/err", 32'({dd_oe, done, bus_err}), 32'd0);
        check("R7", "rdata reset", 32'(rdata), 32'd0);
        check("R7", "disabled at reset", 32'(req_ready), 32'd0);

        // R8: requests while disabled do nothing
        begin
            int act = 0;
            req_valid = 1'b1; req_offset = 8'h40; req_write = 1'b1;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (req_ready || busy || !dior_n || !diow_n || dev_cs != 2'b11) act++;
            end
            req_valid = 1'b0;
            check("R8", "activity while disabled", 32'(act), 32'd0);
        end

        set_en(1'b1);
        // R7: first access uses reset timing 7/13
        access(1'b0, 8'h40, 16'h0, 16'hCAFE, 1'b0, 2'b10, 3'd0);

        // R12: shorter timing on the next access
        set_time(1, 3);
        for (int v = 0; v < NV; v++) begin
            access(VECS[v][46], VECS[v][45:38], VECS[v][37:22], VECS[v][21:6],
                   VECS[v][5], VECS[v][4:3], VECS[v][2:0]);
        end

        // R4/R5: zero counts behave as one
        set_time(0, 0);
        access(1'b0, 8'h5C, 16'h0, 16'h0051, 1'b0, 2'b10, 3'd7);
        access(1'b1, 8'h50, 16'hA0A0, 16'h0, 1'b0, 2'b10, 3'd4);

        // R12: back to slow timing
        set_time(7, 13);
        access(1'b1, 8'h58, 16'h00E0, 16'h0, 1'b0, 2'b10, 3'd6);

        set_en(1'b0);
        @(negedge clk);
        check("R8", "ready after disable", 32'(req_ready), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule